// File: doc/BRIEF.md
# UART Channel Status and Receive Buffer

This block keeps the status byte of one UART channel and the small receive queue behind it. When the deserializer finishes a frame, it presents the data byte, the stop bit it sampled and the parity bit it sampled for one clock as a strobe. The block stores the byte if there is room and records any framing, parity or overrun fault. On the transmit side it registers the busy state of the shifter and the empty state of the transmit holding buffer. When the shifter stops being busy, it raises a sticky end-of-transmission flag.

Software reads the status byte at any time. It clears the four sticky flags by writing ones to their bit positions. It takes received bytes from a read port, one pop per byte, oldest first. When the receive queue is full and another frame arrives, the queue contents are kept and the new byte is dropped together with the shift register contents. Only the overrun flag records the event. Dropping the receive enable clears all four sticky flags.

Top module: `uart_stat_rxbuf`

## Requirements
- R1: After synchronous reset, `status` reads 0x01: only bit 0 (transmit buffer empty) is 1, and the receive queue is empty.
- R2: The `status` bit positions are fixed, from bit 7 down to bit 0: end-of-transmission, framing error, parity error, overrun, two bytes held, transmit busy, receive data ready, transmit buffer empty.
- R3: A write with `csr_wr` high clears each of bits 7..4 whose `csr_wdata` bit is 1. A 0 in `csr_wdata` leaves the flag unchanged. Bits 3..0 ignore writes.
- R4: End-of-transmission (bit 7) sets in the cycle after `tx_busy` is seen low while status bit 2 is still 1.
- R5: A frame strobe with `frame_stop` = 0 sets the framing error flag (bit 6). The byte is still queued if there is room.
- R6: When `parity_en` = 1, a byte entering the queue whose `frame_parity` differs from the XOR of its data bits XOR `parity_odd` sets the parity error flag (bit 5). No check is made when `parity_en` = 0, or when the frame is dropped by an overrun.
- R7: A frame strobe while the queue holds `RX_DEPTH` bytes, with no pop in that cycle, sets the overrun flag (bit 4). The queued bytes and `rd_data` stay unchanged.
- R8: Bit 3 is 1 exactly when the queue holds two or more bytes. It sets when the second byte is loaded and clears when the first byte is popped.
- R9: While `rx_enable` = 0, bits 7..4 are held at 0.
- R10: Bit 1 is 1 whenever the queue holds at least one byte. `rd_data` shows the oldest byte, and `rd_pop` removes it. A pop on an empty queue changes nothing.
- R11: If a set event and a clearing write hit the same sticky flag in one cycle, the flag ends up 1.
- R12: Bits 2 and 0 follow `tx_busy` and `tx_buf_empty` with a one-cycle register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_enable | input | 1 | Receiver enable; 0 clears the sticky flags |
| parity_en | input | 1 | Enables the parity check on queued bytes |
| parity_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| frame_valid | input | 1 | One-cycle strobe: a frame has been received |
| frame_data | input | DATA_W | Received data byte |
| frame_stop | input | 1 | Sampled stop bit |
| frame_parity | input | 1 | Sampled parity bit |
| tx_busy | input | 1 | Transmit shifter busy |
| tx_buf_empty | input | 1 | Transmit holding buffer empty |
| csr_wr | input | 1 | Status write strobe |
| csr_wdata | input | 8 | Status write data (1 clears bits 7..4) |
| status | output | 8 | Status byte |
| rd_pop | input | 1 | Remove the oldest received byte |
| rd_data | output | DATA_W | Oldest received byte |

## Verification
The bench builds the block with its defaults, DATA_W = 8 and RX_DEPTH = 2. At this depth the queue is full exactly when the two-bytes flag is set, so the bench can reach overrun, and the choice of which byte is dropped, with only three frames. The defaults also let it check the two-bytes flag against a real wrap of both pointers. It exercises a write and a set event on the same flag in one cycle, a pop on an empty queue, and a parity fault on a frame that overrun drops. The bench compares the full status byte with an independent model after every clock.

// File: rtl/uart_sb_pkg.sv
package uart_sb_pkg;

    localparam int STAT_W   = 8;
    localparam int N_STICKY = 4;

    // Sticky flag index within status[7:4]
    typedef enum int {
        FL_OVR = 0,
        FL_PAR = 1,
        FL_FRM = 2,
        FL_EOT = 3
    } sticky_idx_e;

    typedef struct packed {
        logic eot;
        logic frm_err;
        logic par_err;
        logic ovr_err;
        logic two_held;
        logic tx_busy;
        logic rx_ready;
        logic tx_empty;
    } stat_t;

    // Parity bit the sender should have produced for this data
    function automatic logic exp_parity(input logic [63:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

endpackage

// File: rtl/uart_sb_sticky.sv
module uart_sb_sticky (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst || !enable) q <= 1'b0;
        else if (set)       q <= 1'b1;
        else if (clr)       q <= 1'b0;
    end
endmodule

// File: rtl/uart_sb_rxfifo.sv
module uart_sb_rxfifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 2,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [CW-1:0]     count
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wdata;
    end

    assign rdata = mem[rd_ptr];
endmodule

// File: rtl/uart_stat_rxbuf.sv
module uart_stat_rxbuf
    import uart_sb_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int RX_DEPTH = 2,
    localparam int CW = $clog2(RX_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_enable,
    input  logic              parity_en,
    input  logic              parity_odd,
    input  logic              frame_valid,
    input  logic [DATA_W-1:0] frame_data,
    input  logic              frame_stop,
    input  logic              frame_parity,
    input  logic              tx_busy,
    input  logic              tx_buf_empty,
    input  logic              csr_wr,
    input  logic [7:0]        csr_wdata,
    output logic [7:0]        status,
    input  logic              rd_pop,
    output logic [DATA_W-1:0] rd_data
);
    logic [CW-1:0]       q_count;
    logic                buf_full, pop_ok, push_ok;
    logic                busy_q, empty_q;
    logic [N_STICKY-1:0] st_set, st_clr, st_q;
    stat_t               stat;

    assign buf_full = (q_count == CW'(RX_DEPTH));
    assign pop_ok   = rd_pop && (q_count != '0);
    assign push_ok  = frame_valid && (!buf_full || pop_ok);

    uart_sb_rxfifo #(.DATA_W(DATA_W), .DEPTH(RX_DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (push_ok),
        .pop   (pop_ok),
        .wdata (frame_data),
        .rdata (rd_data),
        .count (q_count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            empty_q <= 1'b1;
        end else begin
            busy_q  <= tx_busy;
            empty_q <= tx_buf_empty;
        end
    end

    always_comb begin
        st_set         = '0;
        st_set[FL_EOT] = busy_q && !tx_busy;
        st_set[FL_FRM] = frame_valid && !frame_stop;
        st_set[FL_PAR] = push_ok && parity_en &&
                         (frame_parity != exp_parity(64'(frame_data), parity_odd));
        st_set[FL_OVR] = frame_valid && buf_full && !pop_ok;
        st_clr         = csr_wr ? csr_wdata[7:4] : '0;
    end

    for (genvar i = 0; i < N_STICKY; i++) begin : g_sticky
        uart_sb_sticky u_flag (
            .clk    (clk),
            .rst    (rst),
            .enable (rx_enable),
            .set    (st_set[i]),
            .clr    (st_clr[i]),
            .q      (st_q[i])
        );
    end

    always_comb begin
        stat.eot      = st_q[FL_EOT];
        stat.frm_err  = st_q[FL_FRM];
        stat.par_err  = st_q[FL_PAR];
        stat.ovr_err  = st_q[FL_OVR];
        stat.two_held = (q_count >= CW'(2));
        stat.tx_busy  = busy_q;
        stat.rx_ready = (q_count != '0);
        stat.tx_empty = empty_q;
    end

    assign status = stat;
endmodule

// File: rtl/uart_stat_rxbuf_chk.sv
module uart_stat_rxbuf_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              rx_enable,
    input logic              frame_valid,
    input logic              frame_stop,
    input logic              tx_busy,
    input logic              csr_wr,
    input logic [7:0]        csr_wdata,
    input logic [7:0]        status,
    input logic              rd_pop,
    input logic [DATA_W-1:0] rd_data,
    input logic              buf_full
);
    // R1
    p_reset_value_r1: assert property (@(posedge clk)
        rst |=> status == 8'h01);

    // R4
    p_eot_on_fall_r4: assert property (@(posedge clk) disable iff (rst)
        rx_enable && status[2] && !tx_busy |=> status[7]);

    // R5, also R11 when combined with a clearing write
    p_frame_err_r5: assert property (@(posedge clk) disable iff (rst)
        rx_enable && frame_valid && !frame_stop |=> status[6]);

    // R3
    p_w1c_frame_r3: assert property (@(posedge clk) disable iff (rst)
        rx_enable && csr_wr && csr_wdata[6] && !frame_valid |=> !status[6]);

    // R7
    p_overrun_keep_r7: assert property (@(posedge clk) disable iff (rst)
        rx_enable && frame_valid && buf_full && !rd_pop
        |=> status[4] && $stable(rd_data));

    // R9
    p_rx_off_clears_r9: assert property (@(posedge clk) disable iff (rst)
        !rx_enable |=> status[7:4] == 4'h0);

    // R10
    p_ready_with_two_r10: assert property (@(posedge clk) disable iff (rst)
        status[3] |-> status[1]);
endmodule

bind uart_stat_rxbuf uart_stat_rxbuf_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .rx_enable   (rx_enable),
    .frame_valid (frame_valid),
    .frame_stop  (frame_stop),
    .tx_busy     (tx_busy),
    .csr_wr      (csr_wr),
    .csr_wdata   (csr_wdata),
    .status      (status),
    .rd_pop      (rd_pop),
    .rd_data     (rd_data),
    .buf_full    (buf_full)
);

// File: tb/sim_uart_stat_rxbuf.sv
`timescale 1ns/1ps
module sim_uart_stat_rxbuf;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_enable = 1'b1, parity_en = 1'b0, parity_odd = 1'b0;
    logic       frame_valid = 1'b0, frame_stop = 1'b1, frame_parity = 1'b0;
    logic [7:0] frame_data = '0;
    logic       tx_busy = 1'b0, tx_buf_empty = 1'b1;
    logic       csr_wr = 1'b0;
    logic [7:0] csr_wdata = '0;
    logic [7:0] status;
    logic       rd_pop = 1'b0;
    logic [7:0] rd_data;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    // reference model state
    logic [3:0] m_sticky = '0;   // {eot, frm, par, ovr}
    logic       m_busy = 1'b0, m_empty = 1'b1;
    int         m_cnt = 0;
    logic [7:0] expq[$];

    always #2.5 clk = ~clk;

    uart_stat_rxbuf u0 (
        .clk(clk), .rst(rst), .rx_enable(rx_enable), .parity_en(parity_en),
        .parity_odd(parity_odd), .frame_valid(frame_valid), .frame_data(frame_data),
        .frame_stop(frame_stop), .frame_parity(frame_parity), .tx_busy(tx_busy),
        .tx_buf_empty(tx_buf_empty), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
        .status(status), .rd_pop(rd_pop), .rd_data(rd_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: compare popped byte with the scoreboard head
    always @(negedge clk) begin
        if (!rst && rd_pop && expq.size() > 0) begin
            chk("R10 fifo order", {24'h0, rd_data}, {24'h0, expq[0]});
            void'(expq.pop_front());
        end
    end

    // model one clock with the inputs now applied, then compare status
    task automatic tick(input string tag);
        logic [3:0] set, clr;
        logic       full, popv, push;
        full = (m_cnt == 2);
        popv = rd_pop && (m_cnt > 0);
        push = frame_valid && (!full || popv);
        set[3] = m_busy && !tx_busy;
        set[2] = frame_valid && !frame_stop;
        set[1] = push && parity_en && (frame_parity != ((^frame_data) ^ parity_odd));
        set[0] = frame_valid && full && !popv;
        clr = csr_wr ? csr_wdata[7:4] : 4'h0;
        m_sticky = rx_enable ? (set | (m_sticky & ~clr)) : 4'h0;
        if (push) expq.push_back(frame_data);
        m_cnt = m_cnt + (push ? 1 : 0) - (popv ? 1 : 0);
        m_busy = tx_busy;
        m_empty = tx_buf_empty;
        @(posedge clk); #1;
        chk(tag, {24'h0, status},
            {24'h0, m_sticky, (m_cnt >= 2), m_busy, (m_cnt > 0), m_empty});
        frame_valid = 1'b0; csr_wr = 1'b0; rd_pop = 1'b0; csr_wdata = '0;
    endtask

    task automatic send(input logic [7:0] d, input logic stp, input logic par, input string tag);
        frame_data = d; frame_stop = stp; frame_parity = par; frame_valid = 1'b1;
        tick(tag);
    endtask

    task automatic wr(input logic [7:0] v, input string tag);
        csr_wr = 1'b1; csr_wdata = v;
        tick(tag);
    endtask

    task automatic pop(input string tag);
        rd_pop = 1'b1;
        tick(tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset status", {24'h0, status}, 32'h01);
        rst = 1'b0;

        // transmit side
        tx_busy = 1'b1; tx_buf_empty = 1'b0; tick("R12 tx bits follow");
        chk("R2 busy at bit2", {31'h0, status[2]}, 32'h1);
        tx_busy = 1'b0; tx_buf_empty = 1'b1; tick("R4 eot on busy fall");
        chk("R4 eot bit7", {31'h0, status[7]}, 32'h1);
        wr(8'h00, "R3 write zero no effect");
        wr(8'h0F, "R3 read-only bits ignore write");
        wr(8'h80, "R3 clear eot");
        tx_busy = 1'b1; tick("R12 busy again");
        tx_busy = 1'b0; csr_wr = 1'b1; csr_wdata = 8'h80; tick("R11 set beats clear");
        chk("R11 eot kept", {31'h0, status[7]}, 32'h1);
        wr(8'hF0, "R3 clear all sticky");

        // receive queue, parity off
        send(8'hA5, 1'b1, 1'b0, "R6 no check when disabled");
        chk("R10 ready", {31'h0, status[1]}, 32'h1);
        send(8'h3C, 1'b1, 1'b0, "R8 second byte");
        chk("R8 two held", {31'h0, status[3]}, 32'h1);
        send(8'h77, 1'b1, 1'b0, "R7 overrun");
        chk("R7 head kept", {24'h0, rd_data}, 32'hA5);
        pop("R8 clear on first pop");
        pop("R10 second pop");
        pop("R10 pop on empty");
        wr(8'h10, "R3 clear overrun");

        // framing
        send(8'h5A, 1'b0, 1'b0, "R5 framing error");
        chk("R5 byte queued", {24'h0, rd_data}, 32'h5A);
        frame_data = 8'h11; frame_stop = 1'b0; frame_valid = 1'b1;
        csr_wr = 1'b1; csr_wdata = 8'h40; tick("R11 frame set beats clear");
        pop("R10 pop");
        pop("R10 pop");
        wr(8'h40, "R3 clear framing");

        // parity even then odd
        parity_en = 1'b1; parity_odd = 1'b0;
        send(8'h03, 1'b1, 1'b0, "R6 even ok");
        send(8'h01, 1'b1, 1'b0, "R6 even mismatch");
        chk("R6 parity flag", {31'h0, status[5]}, 32'h1);
        pop("R10 pop");
        pop("R10 pop");
        wr(8'h20, "R3 clear parity");
        parity_odd = 1'b1;
        send(8'h00, 1'b1, 1'b1, "R6 odd ok");
        send(8'h00, 1'b1, 1'b1, "R6 odd ok fill");
        send(8'h00, 1'b1, 1'b0, "R6 dropped frame unchecked");
        chk("R6 no parity on overrun", {31'h0, status[5]}, 32'h0);

        // receiver disable
        rx_enable = 1'b0; tick("R9 disable clears");
        chk("R9 sticky zero", {28'h0, status[7:4]}, 32'h0);
        rx_enable = 1'b1;
        pop("R10 drain");
        pop("R10 drain");
        chk("R10 empty", {31'h0, status[1]}, 32'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end
endmodule